// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Controller

This block gathers interrupt events raised by the transmit and receive DMA engines of an Ethernet MAC, plus a link-status change from the RGMII link logic, and keeps each one in a sticky status register. A separate enable register picks which of the held events may reach a single interrupt line. Software reaches both registers over a simple 32-bit register bus. It reads the status and clears events by writing ones back to the bits it wants to drop.

Events arrive as single-cycle pulses. Transmit events use the low byte of the status word, receive events use the second byte, and the link change uses bit 16. Two summary flags group the enabled, pending events. One flag covers normal frame completion and the other covers hard errors. The interrupt line is driven by a two-state machine. In `IRQ_QUIET` the line is low. The transition "assert" moves it to `IRQ_RAISED` when any enabled event is pending. The transition "release" moves it back when nothing enabled is pending. Otherwise the machine holds its state. The line therefore follows the pending condition one clock later.

Top module: `dma_event_irq_ctrl`

## Requirements
- R1: After reset the status register, the enable register, the interrupt line and both summary flags are all zero.
- R2: A pulse on tx_evt[k] sets status bit k on the next clock edge. The bits, from 0 to 5, are: frame sent, DMA halted, no free buffer, timeout, underflow, early transmit.
- R3: A pulse on rx_evt[k] sets status bit 8+k on the next clock edge. The bits, from 8 to 13, are: frame received, no free buffer, DMA halted, timeout, overflow, early receive.
- R4: A pulse on link_evt sets status bit 16 on the next clock edge.
- R5: A write to offset 0x08 clears every status bit that has a one in the write data and leaves the other bits unchanged. Writing back the value just read clears exactly the events that were seen.
- R6: When an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: Offset 0x0C holds the enable mask and reads back what was written. Writing zero masks every source, but masked events still latch in the status register.
- R8: irq is high in the cycle after the one in which (status AND enable) is non-zero, and low in the cycle after the one in which it is zero.
- R9: sum_hard is high exactly when one of status bits 3, 4, 11 or 12 is set and enabled.
- R10: sum_normal is high exactly when status bit 0 or bit 8 is set and enabled.
- R11: Status and enable bits 31:17, 15:14 and 7:6 read as zero and ignore writes. Writing 0x1FFFFFF to 0x08 clears every status bit.
- R12: Reads from any offset other than 0x08 and 0x0C return zero, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_evt | input | 6 | Transmit DMA event pulses |
| rx_evt | input | 6 | Receive DMA event pulses |
| link_evt | input | 1 | Link-status change pulse |
| irq | output | 1 | Registered interrupt line |
| sum_normal | output | 1 | Enabled normal-completion summary |
| sum_hard | output | 1 | Enabled hard-error summary |

## Verification
The assertions assume that event inputs and bus signals are synchronous to clk and stable around each rising edge. They also assume that each write strobe lasts exactly one cycle, with its address and data valid in that cycle. The stimulus changes every input two nanoseconds after a rising edge and holds it for one full cycle. Event pulses are never stretched, so one pulse marks one occurrence. Same-cycle collisions of events and clearing writes are created on purpose so that the priority rule is exercised under these conditions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW       = 32;
    localparam int AW       = 8;
    localparam int TX_LSB   = 0;
    localparam int N_TX     = 6;
    localparam int RX_LSB   = 8;
    localparam int N_RX     = 6;
    localparam int LINK_BIT = 16;

    localparam logic [AW-1:0] STA_OFS = 8'h08;
    localparam logic [AW-1:0] EN_OFS  = 8'h0C;

    // positions inside each field
    localparam int TX_DONE_POS = TX_LSB + 0;
    localparam int TX_TMO_POS  = TX_LSB + 3;
    localparam int TX_UNF_POS  = TX_LSB + 4;
    localparam int RX_DONE_POS = RX_LSB + 0;
    localparam int RX_TMO_POS  = RX_LSB + 3;
    localparam int RX_OVF_POS  = RX_LSB + 4;

    function automatic logic [DW-1:0] field_mask(input int lsb, input int n);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[lsb+i] = 1'b1;
        return m;
    endfunction

    localparam logic [DW-1:0] VALID_MASK = field_mask(TX_LSB, N_TX)
                                         | field_mask(RX_LSB, N_RX)
                                         | field_mask(LINK_BIT, 1);
    localparam logic [DW-1:0] HARD_MASK  = field_mask(TX_TMO_POS, 1)
                                         | field_mask(TX_UNF_POS, 1)
                                         | field_mask(RX_TMO_POS, 1)
                                         | field_mask(RX_OVF_POS, 1);
    localparam logic [DW-1:0] NORM_MASK  = field_mask(TX_DONE_POS, 1)
                                         | field_mask(RX_DONE_POS, 1);

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/irqc_event_map.sv
module irqc_event_map
    import irqc_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [N_TX-1:0] tx_evt,
    input  logic [N_RX-1:0] rx_evt,
    input  logic            link_evt,
    output logic [W-1:0]    evt_vec
);
    always_comb begin
        evt_vec = '0;
        evt_vec[TX_LSB +: N_TX] = tx_evt;
        evt_vec[RX_LSB +: N_RX] = rx_evt;
        evt_vec[LINK_BIT]       = link_evt;
    end
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
    import irqc_pkg::*;
#(
    parameter int            W    = DW,
    parameter logic [W-1:0]  IMPL = VALID_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] sta_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_live
            // a new event outranks a same-cycle clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          sta_q[i] <= 1'b0;
                else if (evt_vec[i]) sta_q[i] <= 1'b1;
                else if (clr_vec[i]) sta_q[i] <= 1'b0;
            end
        end else begin : g_tied
            assign sta_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqc_reg_port.sv
module irqc_reg_port
    import irqc_pkg::*;
#(
    parameter int           W    = DW,
    parameter int           A    = AW,
    parameter logic [W-1:0] IMPL = VALID_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [A-1:0] reg_addr,
    input  logic [W-1:0] reg_wdata,
    input  logic [W-1:0] sta_q,
    output logic [W-1:0] clr_vec,
    output logic [W-1:0] en_q,
    output logic [W-1:0] reg_rdata
);
    logic hit_sta, hit_en;

    always_comb begin
        hit_sta = (reg_addr == STA_OFS);
        hit_en  = (reg_addr == EN_OFS);
        clr_vec = (reg_wr && hit_sta) ? (reg_wdata & IMPL) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               en_q <= '0;
        else if (reg_wr && hit_en) en_q <= reg_wdata & IMPL;
    end

    always_comb begin
        if (hit_sta)     reg_rdata = sta_q;
        else if (hit_en) reg_rdata = en_q;
        else             reg_rdata = '0;
    end
endmodule

// File: rtl/irqc_line_fsm.sv
module irqc_line_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED; // assert
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;  // release
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/dma_event_irq_ctrl.sv
module dma_event_irq_ctrl
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [N_TX-1:0] tx_evt,
    input  logic [N_RX-1:0] rx_evt,
    input  logic            link_evt,
    output logic            irq,
    output logic            sum_normal,
    output logic            sum_hard
);
    logic [DW-1:0] evt_vec, clr_vec, sta_q, en_q, live;

    irqc_event_map #(.W(DW)) i_map (
        .tx_evt(tx_evt), .rx_evt(rx_evt), .link_evt(link_evt), .evt_vec(evt_vec)
    );

    irqc_status_bank #(.W(DW), .IMPL(VALID_MASK)) i_bank (
        .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .clr_vec(clr_vec), .sta_q(sta_q)
    );

    irqc_reg_port #(.W(DW), .A(AW), .IMPL(VALID_MASK)) i_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sta_q(sta_q), .clr_vec(clr_vec),
        .en_q(en_q), .reg_rdata(reg_rdata)
    );

    always_comb begin
        live       = sta_q & en_q;
        sum_normal = |(live & NORM_MASK);
        sum_hard   = |(live & HARD_MASK);
    end

    irqc_line_fsm i_line (
        .clk(clk), .rst_n(rst_n), .pending(|live), .irq(irq)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic [N_TX-1:0] tx_evt,
    input logic [N_RX-1:0] rx_evt,
    input logic            link_evt,
    input logic            irq,
    input logic            sum_normal,
    input logic            sum_hard,
    input logic [DW-1:0]   sta_q,
    input logic [DW-1:0]   en_q
);
    logic [DW-1:0] ev, clr;
    always_comb begin
        ev = '0;
        ev[TX_LSB +: N_TX] = tx_evt;
        ev[RX_LSB +: N_RX] = rx_evt;
        ev[LINK_BIT]       = link_evt;
        clr = (reg_wr && reg_addr == STA_OFS) ? reg_wdata : '0;
    end

    // R2 R3 R4 R6: every pulsed event is held on the next edge, clear or not
    assert_event_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((sta_q & $past(ev)) == $past(ev)));

    // R5: clearing write drops requested bits that saw no new event
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((sta_q & $past(clr) & ~$past(ev)) == '0));

    // R5: bits not cleared stay set
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_q != '0) |=> ((sta_q & $past(sta_q & ~clr)) == $past(sta_q & ~clr)));

    // R8: line follows pending condition one cycle late
    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || !reg_wr) |=> (irq == $past(|(sta_q & en_q))));

    // R9
    assert_hard_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_hard |-> ((sta_q & en_q & HARD_MASK) != '0));

    // R10
    assert_normal_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sum_normal |-> ((sta_q & en_q & NORM_MASK) != '0));

    // R11
    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((sta_q | en_q) & ~VALID_MASK) == '0);
endmodule

bind dma_event_irq_ctrl irqc_checker i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_evt(tx_evt), .rx_evt(rx_evt), .link_evt(link_evt),
    .irq(irq), .sum_normal(sum_normal), .sum_hard(sum_hard),
    .sta_q(sta_q), .en_q(en_q)
);

// File: tb/test_dma_event_irq_ctrl.sv
`timescale 1ns/1ps
module test_dma_event_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  tx_evt = '0;
    logic [5:0]  rx_evt = '0;
    logic        link_evt = 1'b0;
    logic        irq, sum_normal, sum_hard;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_sta = '0, m_en = '0;
    logic        m_irq = 1'b0;
    localparam logic [31:0] IMPL  = 32'h0001_3F3F; // bits 0-5, 8-13, 16 (R11)
    localparam logic [31:0] HARDM = 32'h0000_1818; // bits 3,4,11,12 (R9)
    localparam logic [31:0] NORMM = 32'h0000_0101; // bits 0,8 (R10)

    always #5 clk = ~clk;

    dma_event_irq_ctrl i_dma_event_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .link_evt(link_evt), .irq(irq),
        .sum_normal(sum_normal), .sum_hard(sum_hard)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h08) return m_sta;
        if (a == 8'h0C) return m_en;
        return 32'h0;
    endfunction

    // one clock: model update at the edge, compare 2 ns later, then drop pulses
    task automatic cyc(input string req);
        logic [31:0] ev, clr;
        logic        nirq;
        @(posedge clk);
        ev = 32'(tx_evt) | (32'(rx_evt) << 8) | (32'(link_evt) << 16);
        clr = (reg_wr && reg_addr == 8'h08) ? reg_wdata : 32'h0;
        nirq = |(m_sta & m_en);
        m_sta = ((m_sta & ~clr) | ev) & IMPL;
        if (reg_wr && reg_addr == 8'h0C) m_en = reg_wdata & IMPL;
        m_irq = nirq;
        #2;
        chk({req, " irq R8"}, {31'b0, irq}, {31'b0, m_irq});
        chk({req, " sum_hard R9"}, {31'b0, sum_hard}, {31'b0, |(m_sta & m_en & HARDM)});
        chk({req, " sum_normal R10"}, {31'b0, sum_normal}, {31'b0, |(m_sta & m_en & NORMM)});
        chk({req, " rdata"}, reg_rdata, m_read(reg_addr));
        reg_wr = 1'b0; tx_evt = '0; rx_evt = '0; link_evt = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(req);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk({req, " read"}, reg_rdata, exp);
        cyc(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state
        rd(8'h08, 32'h0, "R1 status");
        rd(8'h0C, 32'h0, "R1 enable");
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R7 R11: enable all, reserved bits dropped
        wr(8'h0C, 32'hFFFF_FFFF, "R7 enable all");
        rd(8'h0C, 32'h0001_3F3F, "R11 enable readback");

        // R2: each transmit source
        for (int k = 0; k < 6; k++) begin
            reg_addr = 8'h08; tx_evt = 6'(1 << k);
            cyc("R2 tx pulse");
            rd(8'h08, 32'(1) << k, "R2 tx bit");
            cyc("R8 irq high");
            wr(8'h08, 32'(1) << k, "R5 clear tx");
            cyc("R8 irq low");
        end
        // R3: each receive source
        for (int k = 0; k < 6; k++) begin
            reg_addr = 8'h08; rx_evt = 6'(1 << k);
            cyc("R3 rx pulse");
            rd(8'h08, 32'(1) << (8 + k), "R3 rx bit");
            wr(8'h08, 32'(1) << (8 + k), "R5 clear rx");
        end
        // R4: link
        reg_addr = 8'h08; link_evt = 1'b1;
        cyc("R4 link pulse");
        rd(8'h08, 32'h0001_0000, "R4 link bit");

        // R5: partial clear and write-back of read value
        tx_evt = 6'h3F; rx_evt = 6'h3F;
        cyc("R5 set many");
        rd(8'h08, 32'h0001_3F3F, "R5 all set");
        wr(8'h08, 32'h0000_0F0F, "R5 partial clear");
        rd(8'h08, 32'h0001_3030, "R5 remainder");
        wr(8'h08, 32'h0001_3030, "R5 write back read value");
        rd(8'h08, 32'h0, "R5 all gone");

        // R6: collision of event and clear on the same bit
        tx_evt = 6'h10;
        cyc("R6 prime");
        reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h0000_0010; tx_evt = 6'h10;
        cyc("R6 collision");
        rd(8'h08, 32'h0000_0010, "R6 bit kept");

        // R9 R10: summaries on hard error and normal
        rx_evt = 6'h01;
        cyc("R10 rx done");
        rx_evt = 6'h10;
        cyc("R9 rx overflow");

        // R11: full clear word
        wr(8'h08, 32'h01FF_FFFF, "R11 clear all");
        rd(8'h08, 32'h0, "R11 cleared");

        // R7: masked sources still latch, line stays low
        wr(8'h0C, 32'h0, "R7 mask all");
        tx_evt = 6'h18; rx_evt = 6'h01; link_evt = 1'b1;
        cyc("R7 masked events");
        rd(8'h08, 32'h0001_0118, "R7 status latched");
        cyc("R7 idle");
        chk("R7 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h0000_0008, "R8 unmask one");
        cyc("R8 raised");
        chk("R8 irq after unmask", {31'b0, irq}, 32'h1);

        // R12: other offsets
        wr(8'h10, 32'hFFFF_FFFF, "R12 stray write");
        wr(8'h04, 32'hFFFF_FFFF, "R12 stray write 2");
        rd(8'h10, 32'h0, "R12 stray read");
        rd(8'h08, 32'h0001_0118, "R12 status untouched");
        rd(8'h0C, 32'h0000_0008, "R12 enable untouched");

        wr(8'h08, 32'h01FF_FFFF, "R11 final clear");
        repeat (3) cyc("R8 settle");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule